// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller Core

This block collects up to 32 external interrupt lines for a small processor and tracks three bits of state per line: enabled, pending and active. Each line also carries a small priority value. On every cycle the block picks the most urgent line that is pending, enabled and not already active. If that line is more urgent than the work the core is already running, the block raises a request with the line's number, its vector number and the byte address of its entry in the vector table.

Software reaches the state through a word-addressed register bus. Enable and pending state each sit behind a pair of registers: one where writing a 1 sets the bit and one where writing a 1 clears it. The core takes a request by pulsing an acknowledge in a cycle where the request is raised. When a handler finishes, the core signals an exception return that names the line. Interrupt inputs are level signals, and the highest line is reserved.

Top module: `irq_ctrl_core`

## Requirements
- R1: Register map by word index on `bus_addr`: 0 is set-enable, 1 is clear-enable, 2 is set-pending, 3 is clear-pending, and 8+k is priority word k. Writing 1 to a bit of set-enable enables that line, and 0 bits have no effect. Reading index 0 or 1 returns the current enable vector.
- R2: Writing 1 to a bit of clear-enable disables that line, and 0 bits have no effect.
- R3: Set-pending and clear-pending follow the same write-1 rules for the pending state. Reading index 2 or 3 returns the current pending vector.
- R4: A line whose input is high while it is disabled becomes pending but is never requested. Its pending bit stays set until something clears it.
- R5: Disabling an active line leaves it active. It keeps the running priority until an exception return.
- R6: A write to clear-pending never changes whether a line is active.
- R7: Line n has its priority in bits [8*(n%4)+7 : 8*(n%4)+6] of priority word n/4. Only these top two bits of each byte are stored, and the other six bits read as zero. A lower value is more urgent.
- R8: Among lines that are pending, enabled and not active, the lowest priority value wins. On a tie the lower line number wins.
- R9: `req_valid` is high only when the winner's priority value is strictly lower than the running level. The running level is the lowest priority value among active lines, or 4 when no line is active.
- R10: `req_vector` equals `req_irq` + 16, and `req_addr` equals 4 × `req_vector`.
- R11: An acknowledge while `req_valid` is high clears the granted line's pending bit and sets its active bit at the same clock edge. An exception return naming a line clears that line's active bit.
- R12: A line whose input is still high pends again at once. This holds after an acknowledge and after a clear-pending write, because setting takes precedence over clearing in the same cycle.
- R13: Line 31 is reserved. It never pends, is never enabled and is never activated, and all its register bits read as zero.
- R14: Reset clears all enable, pending, active and priority state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_LINES (32) | Level interrupt inputs |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not selected |
| req_valid | output | 1 | Interrupt request to the core |
| req_irq | output | IRQ_W (5) | Requested line number |
| req_vector | output | 8 | Vector number of the requested line |
| req_addr | output | 32 | Byte address of the vector-table entry |
| core_ack | input | 1 | Core takes the current request |
| core_ret | input | 1 | Exception return |
| core_ret_irq | input | IRQ_W (5) | Line that the exception return names |

## Verification
The bound checker watches four things on every cycle. A request only ever names a line that is enabled, pending and inactive. An acknowledge always turns the granted line active and not pending. An exception return clears the named active bit. No active bit ever drops except after a return, which covers disabling a running line and clear-pending writes. What the checker cannot judge is which eligible line should have won, so the bench has to show that. It sweeps the priority encoding, the byte packing, tie breaks and the running-level comparison, and it also covers level inputs pending again, the reserved line and the reset values.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

   localparam int unsigned BUS_AW = 4;
   localparam int unsigned BUS_DW = 32;
   localparam int unsigned LINES_PER_WORD = 4;
   localparam int unsigned BYTE_W = 8;

   typedef logic [BUS_AW-1:0] bus_addr_t;
   typedef logic [BUS_DW-1:0] bus_word_t;

   localparam bus_addr_t OFS_EN_SET   = 4'd0;
   localparam bus_addr_t OFS_EN_CLR   = 4'd1;
   localparam bus_addr_t OFS_PND_SET  = 4'd2;
   localparam bus_addr_t OFS_PND_CLR  = 4'd3;
   localparam bus_addr_t OFS_PRI_BASE = 4'd8;

   typedef struct packed {
      bus_word_t set_en;
      bus_word_t clr_en;
      bus_word_t set_pnd;
      bus_word_t clr_pnd;
   } wr_strobe_t;

endpackage

// File: rtl/irq_bus_port.sv
module irq_bus_port
   import irq_ctrl_pkg::*;
#(
   parameter int unsigned NUM_LINES = 32,
   parameter int unsigned PRIO_BITS = 2
) (
   input  logic                           bus_sel,
   input  logic                           bus_wr,
   input  bus_addr_t                      bus_addr,
   input  bus_word_t                      bus_wdata,
   input  logic [NUM_LINES-1:0]           en_vec,
   input  logic [NUM_LINES-1:0]           pend_vec,
   input  logic [NUM_LINES*PRIO_BITS-1:0] prio_flat,
   output wr_strobe_t                     strb,
   output logic [NUM_LINES-1:0]           prio_we,
   output logic [NUM_LINES*PRIO_BITS-1:0] prio_wval,
   output bus_word_t                      bus_rdata
);

   localparam int unsigned NPREG  = (NUM_LINES + LINES_PER_WORD - 1) / LINES_PER_WORD;
   localparam int unsigned PIDX_W = $clog2(NPREG);
   localparam int unsigned PSHIFT = BYTE_W - PRIO_BITS;

   logic                    wr_go;
   bus_addr_t               pri_off;
   logic                    in_pri;
   logic [NPREG*BUS_DW-1:0] pri_rd;

   assign wr_go   = bus_sel & bus_wr;
   assign pri_off = bus_addr - OFS_PRI_BASE;
   assign in_pri  = (bus_addr >= OFS_PRI_BASE) && (pri_off < BUS_AW'(NPREG));

   // write strobe decode for the paired set / clear registers
   always_comb begin
      strb = '0;
      if (wr_go) begin
         case (bus_addr)
            OFS_EN_SET:  strb.set_en  = bus_wdata;
            OFS_EN_CLR:  strb.clr_en  = bus_wdata;
            OFS_PND_SET: strb.set_pnd = bus_wdata;
            OFS_PND_CLR: strb.clr_pnd = bus_wdata;
            default:     strb = '0;
         endcase
      end
   end

   // per-line priority write lanes: line i lives in byte i%4 of word i/4
   for (genvar i = 0; i < NUM_LINES; i++) begin : g_pwr
      localparam int unsigned WIDX = i / LINES_PER_WORD;
      localparam int unsigned BIDX = i % LINES_PER_WORD;
      assign prio_we[i] = wr_go && (bus_addr == OFS_PRI_BASE + BUS_AW'(WIDX));
      assign prio_wval[i*PRIO_BITS +: PRIO_BITS] =
         bus_wdata[BYTE_W*BIDX + BYTE_W - 1 -: PRIO_BITS];
   end

   // readback words: stored bits go to the top of each byte, the rest read 0
   for (genvar r = 0; r < NPREG; r++) begin : g_prd
      for (genvar b = 0; b < LINES_PER_WORD; b++) begin : g_byte
         localparam int unsigned LN = r * LINES_PER_WORD + b;
         if (LN < NUM_LINES) begin : g_live
            assign pri_rd[r*BUS_DW + b*BYTE_W +: BYTE_W] =
               BYTE_W'(prio_flat[LN*PRIO_BITS +: PRIO_BITS]) << PSHIFT;
         end else begin : g_pad
            assign pri_rd[r*BUS_DW + b*BYTE_W +: BYTE_W] = '0;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel) begin
         if ((bus_addr == OFS_EN_SET) || (bus_addr == OFS_EN_CLR)) begin
            bus_rdata[NUM_LINES-1:0] = en_vec;
         end else if ((bus_addr == OFS_PND_SET) || (bus_addr == OFS_PND_CLR)) begin
            bus_rdata[NUM_LINES-1:0] = pend_vec;
         end else if (in_pri) begin
            bus_rdata = pri_rd[pri_off[PIDX_W-1:0]*BUS_DW +: BUS_DW];
         end
      end
   end

endmodule

// File: rtl/irq_line_state.sv
module irq_line_state
   import irq_ctrl_pkg::*;
#(
   parameter int unsigned NUM_LINES     = 32,
   parameter int unsigned PRIO_BITS     = 2,
   parameter logic [31:0] RESERVED_MASK = 32'h8000_0000,
   localparam int unsigned IRQ_W        = $clog2(NUM_LINES)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_LINES-1:0]           irq_in,
   input  wr_strobe_t                     strb,
   input  logic [NUM_LINES-1:0]           prio_we,
   input  logic [NUM_LINES*PRIO_BITS-1:0] prio_wval,
   input  logic                           ack_fire,
   input  logic [IRQ_W-1:0]               ack_irq,
   input  logic                           ret_fire,
   input  logic [IRQ_W-1:0]               ret_irq,
   output logic [NUM_LINES-1:0]           en_vec,
   output logic [NUM_LINES-1:0]           pend_vec,
   output logic [NUM_LINES-1:0]           act_vec,
   output logic [NUM_LINES*PRIO_BITS-1:0] prio_flat
);

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      if (RESERVED_MASK[i]) begin : g_rsv
         // a reserved line holds no state at all
         assign en_vec[i]   = 1'b0;
         assign pend_vec[i] = 1'b0;
         assign act_vec[i]  = 1'b0;
         assign prio_flat[i*PRIO_BITS +: PRIO_BITS] = '0;
      end else begin : g_live
         logic                 en_q, pnd_q, act_q;
         logic [PRIO_BITS-1:0] pri_q;
         logic                 take_hit, ret_hit, pnd_set, pnd_clr;

         assign take_hit = ack_fire && (ack_irq == IRQ_W'(i));
         assign ret_hit  = ret_fire && (ret_irq == IRQ_W'(i));
         assign pnd_set  = irq_in[i] | strb.set_pnd[i];
         assign pnd_clr  = strb.clr_pnd[i] | take_hit;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               en_q  <= 1'b0;
               pnd_q <= 1'b0;
               act_q <= 1'b0;
               pri_q <= '0;
            end else begin
               if (strb.set_en[i]) begin
                  en_q <= 1'b1;
               end else if (strb.clr_en[i]) begin
                  en_q <= 1'b0;
               end
               // setting sources win: a held level re-pends at once
               if (pnd_set) begin
                  pnd_q <= 1'b1;
               end else if (pnd_clr) begin
                  pnd_q <= 1'b0;
               end
               if (take_hit) begin
                  act_q <= 1'b1;
               end else if (ret_hit) begin
                  act_q <= 1'b0;
               end
               if (prio_we[i]) begin
                  pri_q <= prio_wval[i*PRIO_BITS +: PRIO_BITS];
               end
            end
         end

         assign en_vec[i]   = en_q;
         assign pend_vec[i] = pnd_q;
         assign act_vec[i]  = act_q;
         assign prio_flat[i*PRIO_BITS +: PRIO_BITS] = pri_q;
      end
   end

endmodule

// File: rtl/irq_select.sv
module irq_select #(
   parameter int unsigned NUM_LINES = 32,
   parameter int unsigned PRIO_BITS = 2,
   parameter bit          ARB_TREE  = 1'b1,
   localparam int unsigned IRQ_W    = $clog2(NUM_LINES)
) (
   input  logic [NUM_LINES-1:0]           elig,
   input  logic [NUM_LINES-1:0]           act_vec,
   input  logic [NUM_LINES*PRIO_BITS-1:0] prio_flat,
   output logic                           req_valid,
   output logic [IRQ_W-1:0]               win_irq
);

   localparam int unsigned LVL_W = PRIO_BITS + 1;
   localparam logic [LVL_W-1:0] LVL_IDLE = {1'b1, {PRIO_BITS{1'b0}}};

   logic                 win_vld;
   logic [PRIO_BITS-1:0] win_prio;
   logic [LVL_W-1:0]     run_lvl;

   // running level: most urgent priority among active lines
   always_comb begin
      run_lvl = LVL_IDLE;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (act_vec[i] && ({1'b0, prio_flat[i*PRIO_BITS +: PRIO_BITS]} < run_lvl)) begin
            run_lvl = {1'b0, prio_flat[i*PRIO_BITS +: PRIO_BITS]};
         end
      end
   end

   if (ARB_TREE) begin : g_tree
      localparam int unsigned N2    = 1 << IRQ_W;
      localparam int unsigned NODES = 2 * N2 - 1;

      logic                 n_vld  [NODES];
      logic [PRIO_BITS-1:0] n_prio [NODES];
      logic [IRQ_W-1:0]     n_idx  [NODES];

      for (genvar j = 0; j < N2; j++) begin : g_leaf
         if (j < NUM_LINES) begin : g_real
            assign n_vld[N2-1+j]  = elig[j];
            assign n_prio[N2-1+j] = prio_flat[j*PRIO_BITS +: PRIO_BITS];
            assign n_idx[N2-1+j]  = IRQ_W'(j);
         end else begin : g_pad
            assign n_vld[N2-1+j]  = 1'b0;
            assign n_prio[N2-1+j] = '0;
            assign n_idx[N2-1+j]  = '0;
         end
      end

      // left subtree holds lower line numbers, so it wins ties
      for (genvar k = 0; k < N2 - 1; k++) begin : g_node
         logic take_l;
         assign take_l = n_vld[2*k+1] &&
                         (!n_vld[2*k+2] || (n_prio[2*k+1] <= n_prio[2*k+2]));
         assign n_vld[k]  = n_vld[2*k+1] | n_vld[2*k+2];
         assign n_prio[k] = take_l ? n_prio[2*k+1] : n_prio[2*k+2];
         assign n_idx[k]  = take_l ? n_idx[2*k+1]  : n_idx[2*k+2];
      end

      assign win_vld  = n_vld[0];
      assign win_prio = n_prio[0];
      assign win_irq  = n_idx[0];
   end else begin : g_scan
      always_comb begin
         win_vld  = 1'b0;
         win_prio = '0;
         win_irq  = '0;
         for (int i = 0; i < NUM_LINES; i++) begin
            if (elig[i] && (!win_vld || (prio_flat[i*PRIO_BITS +: PRIO_BITS] < win_prio))) begin
               win_vld  = 1'b1;
               win_prio = prio_flat[i*PRIO_BITS +: PRIO_BITS];
               win_irq  = IRQ_W'(i);
            end
         end
      end
   end

   assign req_valid = win_vld && ({1'b0, win_prio} < run_lvl);

endmodule

// File: rtl/irq_vector_map.sv
module irq_vector_map #(
   parameter int unsigned IRQ_W      = 5,
   parameter int unsigned VEC_BASE   = 16,
   parameter logic [31:0] TABLE_BASE = 32'h0
) (
   input  logic [IRQ_W-1:0] irq,
   output logic [7:0]       vector,
   output logic [31:0]      addr
);

   assign vector = 8'(irq) + 8'(VEC_BASE);
   assign addr   = TABLE_BASE + {22'd0, vector, 2'b00};

endmodule

// File: rtl/irq_ctrl_core.sv
module irq_ctrl_core
   import irq_ctrl_pkg::*;
#(
   parameter int unsigned NUM_LINES     = 32,
   parameter int unsigned PRIO_BITS     = 2,
   parameter logic [31:0] RESERVED_MASK = 32'h8000_0000,
   parameter int unsigned VEC_BASE      = 16,
   parameter logic [31:0] TABLE_BASE    = 32'h0,
   parameter bit          ARB_TREE      = 1'b1,
   localparam int unsigned IRQ_W        = $clog2(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_in,
   input  logic                 bus_sel,
   input  logic                 bus_wr,
   input  logic [3:0]           bus_addr,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   output logic                 req_valid,
   output logic [IRQ_W-1:0]     req_irq,
   output logic [7:0]           req_vector,
   output logic [31:0]          req_addr,
   input  logic                 core_ack,
   input  logic                 core_ret,
   input  logic [IRQ_W-1:0]     core_ret_irq
);

   if (NUM_LINES < 8 || NUM_LINES > 32) begin : g_bad_lines
      $error("irq_ctrl_core: NUM_LINES must lie in 8..32");
   end
   if (PRIO_BITS < 1 || PRIO_BITS > 8) begin : g_bad_prio
      $error("irq_ctrl_core: PRIO_BITS must lie in 1..8");
   end
   if (VEC_BASE + NUM_LINES > 256) begin : g_bad_vec
      $error("irq_ctrl_core: vector numbers exceed 8 bits");
   end

   wr_strobe_t                     strb;
   logic [NUM_LINES-1:0]           prio_we;
   logic [NUM_LINES*PRIO_BITS-1:0] prio_wval;
   logic [NUM_LINES-1:0]           en_vec, pend_vec, act_vec;
   logic [NUM_LINES*PRIO_BITS-1:0] prio_flat;
   logic [NUM_LINES-1:0]           elig;
   logic                           ack_fire;

   assign elig     = pend_vec & en_vec & ~act_vec;
   assign ack_fire = core_ack & req_valid;

   irq_bus_port #(
      .NUM_LINES (NUM_LINES),
      .PRIO_BITS (PRIO_BITS)
   ) bus_i (
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .en_vec    (en_vec),
      .pend_vec  (pend_vec),
      .prio_flat (prio_flat),
      .strb      (strb),
      .prio_we   (prio_we),
      .prio_wval (prio_wval),
      .bus_rdata (bus_rdata)
   );

   irq_line_state #(
      .NUM_LINES     (NUM_LINES),
      .PRIO_BITS     (PRIO_BITS),
      .RESERVED_MASK (RESERVED_MASK)
   ) state_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_in    (irq_in),
      .strb      (strb),
      .prio_we   (prio_we),
      .prio_wval (prio_wval),
      .ack_fire  (ack_fire),
      .ack_irq   (req_irq),
      .ret_fire  (core_ret),
      .ret_irq   (core_ret_irq),
      .en_vec    (en_vec),
      .pend_vec  (pend_vec),
      .act_vec   (act_vec),
      .prio_flat (prio_flat)
   );

   irq_select #(
      .NUM_LINES (NUM_LINES),
      .PRIO_BITS (PRIO_BITS),
      .ARB_TREE  (ARB_TREE)
   ) sel_i (
      .elig      (elig),
      .act_vec   (act_vec),
      .prio_flat (prio_flat),
      .req_valid (req_valid),
      .win_irq   (req_irq)
   );

   irq_vector_map #(
      .IRQ_W      (IRQ_W),
      .VEC_BASE   (VEC_BASE),
      .TABLE_BASE (TABLE_BASE)
   ) vec_i (
      .irq    (req_irq),
      .vector (req_vector),
      .addr   (req_addr)
   );

endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
   parameter int unsigned NUM_LINES = 32,
   parameter int unsigned IRQ_W     = 5
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] irq_in,
   input logic                 bus_sel,
   input logic                 bus_wr,
   input logic [NUM_LINES-1:0] en_vec,
   input logic [NUM_LINES-1:0] pend_vec,
   input logic [NUM_LINES-1:0] act_vec,
   input logic                 req_valid,
   input logic [IRQ_W-1:0]     req_irq,
   input logic                 core_ack,
   input logic                 core_ret,
   input logic [IRQ_W-1:0]     core_ret_irq
);

   // R4
   req_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> en_vec[req_irq]);

   // R8
   req_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (pend_vec[req_irq] && !act_vec[req_irq]));

   // R11
   ack_activates_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && core_ack) |=> act_vec[$past(req_irq)]);

   // R11
   ack_unpends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && core_ack && !irq_in[req_irq] && !(bus_sel && bus_wr))
      |=> !pend_vec[$past(req_irq)]);

   // R11
   ret_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (core_ret && !(req_valid && core_ack && (req_irq == core_ret_irq)))
      |=> !act_vec[$past(core_ret_irq)]);

   // R5 R6
   active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|($past(act_vec) & ~act_vec)) |-> $past(core_ret));

endmodule

bind irq_ctrl_core irq_ctrl_chk #(
   .NUM_LINES (NUM_LINES),
   .IRQ_W     (IRQ_W)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .irq_in       (irq_in),
   .bus_sel      (bus_sel),
   .bus_wr       (bus_wr),
   .en_vec       (en_vec),
   .pend_vec     (pend_vec),
   .act_vec      (act_vec),
   .req_valid    (req_valid),
   .req_irq      (req_irq),
   .core_ack     (core_ack),
   .core_ret     (core_ret),
   .core_ret_irq (core_ret_irq)
);

// File: tb/irq_ctrl_core_tb_top.sv
`timescale 1ns/1ps
module irq_ctrl_core_tb_top;

   localparam logic [31:0] RSV = 32'h8000_0000;
   localparam logic [3:0] A_ENS = 4'd0, A_ENC = 4'd1, A_PNS = 4'd2, A_PNC = 4'd3, A_PRI = 4'd8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_in = '0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        req_valid;
   logic [4:0]  req_irq;
   logic [7:0]  req_vector;
   logic [31:0] req_addr;
   logic        core_ack = 1'b0, core_ret = 1'b0;
   logic [4:0]  core_ret_irq = '0;

   int  total = 0;
   int  bad = 0;
   bit  done = 1'b0;

   always #2 clk = ~clk;

   irq_ctrl_core dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .irq_in       (irq_in),
      .bus_sel      (bus_sel),
      .bus_wr       (bus_wr),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .req_valid    (req_valid),
      .req_irq      (req_irq),
      .req_vector   (req_vector),
      .req_addr     (req_addr),
      .core_ack     (core_ack),
      .core_ret     (core_ret),
      .core_ret_irq (core_ret_irq)
   );

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic rd_chk(input string rq, input logic [3:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(rq, d, exp);
   endtask

   // checks the request outputs; line < 0 means no request expected
   task automatic req_chk(input string rq, input int line);
      @(negedge clk);
      #1;
      if (line < 0) begin
         chk(rq, {31'd0, req_valid}, 32'd0);
      end else begin
         chk(rq, {31'd0, req_valid}, 32'd1);
         chk(rq, {27'd0, req_irq}, line);
         chk("R10", {24'd0, req_vector}, line + 16);
         chk("R10", req_addr, 4 * (line + 16));
      end
   endtask

   task automatic ack();
      @(negedge clk); core_ack = 1'b1;
      @(negedge clk); core_ack = 1'b0;
   endtask

   task automatic ret(input int line);
      @(negedge clk); core_ret = 1'b1; core_ret_irq = 5'(line);
      @(negedge clk); core_ret = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; irq_in = '0; core_ack = 1'b0; core_ret = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   function automatic int pmap(int rnd, int i);
      case (rnd)
         0:       return (i * 5 + 1) % 4;
         1:       return (i * 3 + 2) % 4;
         2:       return 0;
         default: return ((31 - i) / 8) % 4;
      endcase
   endfunction

   function automatic int pick(logic [31:0] m, int rnd);
      int best = -1;
      int bp = 99;
      for (int i = 0; i < 31; i++) begin
         if (m[i] && pmap(rnd, i) < bp) begin
            best = i; bp = pmap(rnd, i);
         end
      end
      return best;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] model;
      logic [31:0] xs;
      logic [31:0] m;
      logic [31:0] pw;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R14: reset state of every register index and of the request
      for (int a = 0; a < 16; a++) rd_chk("R14", 4'(a), 32'd0);
      req_chk("R14", -1);

      // R1 R13: set-enable sweep, zero bits ignored, both indices read back
      model = '0;
      wr(A_ENS, 32'd0);
      rd_chk("R1", A_ENS, 32'd0);
      for (int i = 0; i < 32; i++) begin
         wr(A_ENS, 32'd1 << i);
         model |= (32'd1 << i) & ~RSV;
         rd_chk("R1", A_ENS, model);
         rd_chk("R1", A_ENC, model);
      end
      // R2: clear-enable sweep
      wr(A_ENC, 32'd0);
      rd_chk("R2", A_ENS, model);
      for (int i = 0; i < 32; i++) begin
         wr(A_ENC, 32'd1 << i);
         model &= ~(32'd1 << i);
         rd_chk("R2", A_ENC, model);
      end

      // R3: pending pair sweep with all lines disabled
      model = '0;
      for (int i = 0; i < 32; i++) begin
         wr(A_PNS, 32'h0000_0005 << i);
         model |= (32'h0000_0005 << i) & ~RSV;
         rd_chk("R3", A_PNS, model);
      end
      for (int i = 0; i < 32; i++) begin
         wr(A_PNC, 32'd1 << i);
         model &= ~(32'd1 << i);
         rd_chk("R3", A_PNC, model);
      end

      // R7: priority packing over all words, low six bits of each byte dropped
      for (int r = 0; r < 8; r++) wr(A_PRI + 4'(r), 32'hA5C3_96F0 ^ (32'h1357_9BDF * r));
      for (int r = 0; r < 8; r++) begin
         m = (32'hA5C3_96F0 ^ (32'h1357_9BDF * r)) & 32'hC0C0_C0C0;
         if (r == 7) m[31:24] = 8'h00;
         rd_chk("R7", A_PRI + 4'(r), m);
      end

      // R8 R10: arbitration sweep over priority maps and pending masks
      do_reset();
      wr(A_ENS, 32'hFFFF_FFFF);
      xs = 32'h1F2E_3D4C;
      for (int rnd = 0; rnd < 4; rnd++) begin
         for (int r = 0; r < 8; r++) begin
            pw = '0;
            for (int b = 0; b < 4; b++) pw[8*b +: 8] = 8'(pmap(rnd, 4 * r + b)) << 6;
            wr(A_PRI + 4'(r), pw);
         end
         for (int k = 0; k < 12; k++) begin
            xs ^= xs << 13; xs ^= xs >> 17; xs ^= xs << 5;
            if (k == 0)          m = RSV;
            else if (k % 2 == 1) m = xs;
            else                 m = xs & (xs >> 5) & (xs >> 11);
            wr(A_PNC, 32'hFFFF_FFFF);
            wr(A_PNS, m);
            req_chk("R8", pick(m, rnd));
         end
      end
      // R8: explicit tie among equal priorities goes to the lower number
      for (int r = 0; r < 8; r++) wr(A_PRI + 4'(r), 32'h0);
      wr(A_PNC, 32'hFFFF_FFFF);
      wr(A_PNS, 32'h00F0_0100);
      req_chk("R8", 8);
      wr(A_PNC, 32'hFFFF_FFFF);

      // R4: a disabled line pends but is not requested
      do_reset();
      wr(A_PRI, 32'h0040_0000);   // line 2 priority 1
      wr(A_PRI + 4'd1, 32'h0000_0040); // line 4 priority 1, line 5 priority 0
      @(negedge clk); irq_in[2] = 1'b1;
      @(negedge clk); @(negedge clk);
      rd_chk("R4", A_PNS, 32'h4);
      req_chk("R4", -1);
      @(negedge clk); irq_in[2] = 1'b0;
      wr(A_ENS, 32'h4);
      req_chk("R4", 2);
      // R11: acknowledge clears pending and makes the line active
      ack();
      rd_chk("R11", A_PNS, 32'h0);
      req_chk("R11", -1);
      wr(A_PNS, 32'h4);
      req_chk("R11", -1);
      rd_chk("R11", A_PNC, 32'h4);

      // R5: disabling the active line keeps its running level
      wr(A_ENC, 32'h4);
      wr(A_ENS, 32'h10);
      wr(A_PNS, 32'h10);
      req_chk("R5", -1);
      // R6: clear-pending on the active line leaves it active
      wr(A_PNC, 32'h4);
      rd_chk("R6", A_PNS, 32'h10);
      req_chk("R6", -1);
      // R9: a strictly more urgent line preempts the running level
      wr(A_ENS, 32'h20);
      wr(A_PNS, 32'h20);
      req_chk("R9", 5);
      wr(A_PNC, 32'h20);
      req_chk("R9", -1);
      // R11: exception return releases the running level
      ret(2);
      req_chk("R11", 4);

      // R12: held level re-pends after acknowledge and clear-pending
      do_reset();
      wr(A_ENS, 32'h80);
      @(negedge clk); irq_in[7] = 1'b1;
      req_chk("R12", 7);
      ack();
      rd_chk("R12", A_PNS, 32'h80);
      req_chk("R12", -1);
      wr(A_PNC, 32'h80);
      rd_chk("R12", A_PNS, 32'h80);
      @(negedge clk); irq_in[7] = 1'b0;
      wr(A_PNC, 32'h80);
      rd_chk("R12", A_PNS, 32'h0);
      ret(7);
      req_chk("R11", -1);
      wr(A_PNS, 32'h80);
      req_chk("R11", 7);
      wr(A_PNC, 32'h80);

      // R13: reserved line holds no state
      wr(A_ENS, 32'hFFFF_FFFF);
      rd_chk("R13", A_ENC, 32'h7FFF_FFFF);
      @(negedge clk); irq_in[31] = 1'b1;
      wr(A_PNS, RSV);
      rd_chk("R13", A_PNS, 32'h0);
      req_chk("R13", -1);
      wr(A_PRI + 4'd7, 32'hFFFF_FFFF);
      rd_chk("R13", A_PRI + 4'd7, 32'h00C0_C0C0);

      // R14: reset wipes live state
      wr(A_PNS, 32'h0000_0300);
      do_reset();
      rd_chk("R14", A_ENS, 32'h0);
      rd_chk("R14", A_PNS, 32'h0);
      rd_chk("R14", A_PRI + 4'd7, 32'h0);
      req_chk("R14", -1);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule